// File: doc/BRIEF.md
# Indexed Compare/Capture Timer Array

This block gives a small number of timing channels one shared free-running time base. Each channel either records the time base when an event arrives (capture) or watches for the time base to reach a programmed value (compare). A capture event is a rising or falling edge on the channel's own pin, the time base reaching its top value, or any change on a shared comparator input. A compare match can toggle the channel's output. In either mode a hit can restart the time base from zero.

Software sees four byte locations. The first selects a channel. The other three expose that channel's control byte, the low byte of its data and the high byte of its data. Channel registers have no addresses of their own. A 16-bit data value is written high byte first: the high byte is held aside and goes into the channel together with the low byte. Every channel has a sticky flag, and the flags are ORed into one interrupt request.

Top module: `ccap_array`

## Requirements
- R1: While reset is asserted, the time base, all outputs, the interrupt request, the index and every channel's control and data registers are zero, so every channel starts in capture mode.
- R2: The time base rises by one each clock cycle and wraps from its maximum value to zero.
- R3: Byte address 0 holds the channel index, and only its low log2(channels) bits are kept. Address 1 reads and writes the control byte of the indexed channel, address 2 its data low byte and address 3 its data high byte. Other channels are not affected.
- R4: A write to address 3 does not change the channel data: reading address 3 still returns the old value. The next write to address 2 loads the held high byte and the new low byte together. High-byte bits above the time base width read as zero.
- R5: Control bit0 = 0 selects capture. Source bits 4:3 = 00 capture on a rising pin edge and 01 on a falling pin edge. The stored value is the time base value visible after the second rising clock edge that follows the pin change, and the flag (bit7) is set on the same edge as the data.
- R6: Source 10 captures while the time base holds its maximum value, so it stores the all-ones value.
- R7: Source 11 captures on both rising and falling changes of the comparator input, with the same latency as R5.
- R8: Control bit0 = 1 selects compare. When the time base equals the data register, the flag is set on the next edge, and if bit2 = 1 the channel output toggles on that edge.
- R9: With bit1 = 1, a capture or a match makes the time base read zero after the next edge, in place of the increment. Two channels clearing in the same cycle give a single clear, and a match value of N gives a period of N+1 cycles.
- R10: The flag is sticky. A control write with bit7 = 0 clears it, and a write with bit7 = 1 leaves it as it was. Bits 6:5 read as zero. The interrupt request is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Byte location: 0 index, 1 control, 2 data low, 3 data high |
| reg_wr | input | 1 | Write strobe for reg_wdata |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of reg_addr, combinational |
| pin_in | input | NCH | Per-channel asynchronous event pins |
| cmp_in | input | 1 | Shared asynchronous comparator input |
| chan_out | output | NCH | Per-channel toggle outputs |
| irq | output | 1 | OR of all channel flags |
| tbase | output | TW | Current time base value |

## Verification
The bench builds the array with four channels and a 12-bit time base. With that width the time base wraps every 4096 cycles, so overflow capture and wrap-around come within a short run. The width also leaves the high data byte only partly used, which exercises the masking of unused high bits. A compare period of 21 cycles shows the clear path several times without waiting for a wrap.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  // control byte field positions
  localparam int CB_MODE = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_TGL  = 2;
  localparam int CB_SRC0 = 3;
  localparam int CB_SRC1 = 4;
  localparam int CB_FLAG = 7;

  typedef enum logic [1:0] {
    SRC_RISE = 2'b00,
    SRC_FALL = 2'b01,
    SRC_OVF  = 2'b10,
    SRC_CMP  = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    WIN_IDX  = 2'd0,
    WIN_CTRL = 2'd1,
    WIN_LO   = 2'd2,
    WIN_HI   = 2'd3
  } win_e;
endpackage

// File: rtl/ccap_sync.sv
module ccap_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= async_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/ccap_timebase.sv
module ccap_timebase #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  output logic [TW-1:0] count,
  output logic          at_max
);
  logic [TW-1:0] count_q, count_n;

  always_comb begin
    if (clr) count_n = '0;
    else     count_n = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_n;
  end

  assign count  = count_q;
  assign at_max = &count_q;
endmodule

// File: rtl/ccap_channel.sv
module ccap_channel
  import ccap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [TW-1:0] tbase,
  input  logic          ovf_evt,
  input  logic          pin_rise,
  input  logic          pin_fall,
  input  logic          cmp_chg,
  input  logic          ctrl_we,
  input  logic          data_we,
  input  logic [7:0]    wbyte,
  input  logic [TW-1:0] wdata_full,
  output logic [7:0]    ctrl_rd,
  output logic [TW-1:0] data_rd,
  output logic          hit,
  output logic          clr_req,
  output logic          flag,
  output logic          out
);
  logic [4:0]    cfg_q, cfg_n;
  logic          flag_q, flag_n;
  logic [TW-1:0] data_q, data_n;
  logic          out_q, out_n;
  logic          evt;
  logic          is_cmp;

  assign is_cmp = cfg_q[CB_MODE];

  always_comb begin
    unique case (src_e'(cfg_q[CB_SRC1:CB_SRC0]))
      SRC_RISE: evt = pin_rise;
      SRC_FALL: evt = pin_fall;
      SRC_OVF:  evt = ovf_evt;
      default:  evt = cmp_chg;
    endcase
  end

  assign hit     = is_cmp ? (tbase == data_q) : evt;
  assign clr_req = hit & cfg_q[CB_CLR];

  always_comb begin
    cfg_n  = cfg_q;
    flag_n = flag_q;
    data_n = data_q;
    out_n  = out_q;
    if (ctrl_we) begin
      cfg_n  = wbyte[4:0];
      flag_n = flag_q & wbyte[CB_FLAG];
    end
    if (hit) flag_n = 1'b1;
    if (data_we)               data_n = wdata_full;
    else if (hit && !is_cmp)   data_n = tbase;
    if (hit && is_cmp && cfg_q[CB_TGL]) out_n = ~out_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      data_q <= '0;
      out_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      flag_q <= flag_n;
      data_q <= data_n;
      out_q  <= out_n;
    end
  end

  assign ctrl_rd = {flag_q, 2'b00, cfg_q};
  assign data_rd = data_q;
  assign flag    = flag_q;
  assign out     = out_q;
endmodule

// File: rtl/ccap_array.sv
module ccap_array
  import ccap_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     reg_addr,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] pin_in,
  input  logic           cmp_in,
  output logic [NCH-1:0] chan_out,
  output logic           irq,
  output logic [TW-1:0]  tbase
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HW = TW - 8;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_q1, rst_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_i = rst_q2;

  // index and held high byte
  logic [IW-1:0] idx_q, idx_n;
  logic [HW-1:0] hold_q, hold_n;
  logic          idx_we, hold_we, ctrl_wr, lo_wr;

  assign idx_we  = reg_wr && (win_e'(reg_addr) == WIN_IDX);
  assign ctrl_wr = reg_wr && (win_e'(reg_addr) == WIN_CTRL);
  assign lo_wr   = reg_wr && (win_e'(reg_addr) == WIN_LO);
  assign hold_we = reg_wr && (win_e'(reg_addr) == WIN_HI);

  always_comb begin
    idx_n  = idx_we  ? reg_wdata[IW-1:0] : idx_q;
    hold_n = hold_we ? reg_wdata[HW-1:0] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      idx_q  <= idx_n;
      hold_q <= hold_n;
    end
  end

  // shared time base and event detection
  logic [NCH-1:0] clr_v, hit_v, flag_v;
  logic           clr_any, ovf;
  logic [NCH:0]   rise_v, fall_v;

  assign clr_any = |clr_v;

  ccap_timebase #(.TW(TW)) u_tb (
    .clk(clk), .rst_ni(rst_i), .clr(clr_any), .count(tbase), .at_max(ovf)
  );

  ccap_sync #(.W(NCH + 1)) u_sync (
    .clk(clk), .rst_ni(rst_i), .async_in({cmp_in, pin_in}),
    .rise(rise_v), .fall(fall_v)
  );

  logic [7:0]    ctrl_rd [NCH];
  logic [TW-1:0] data_rd [NCH];
  logic [TW-1:0] wfull;
  assign wfull = {hold_q, reg_wdata};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = (idx_q == IW'(g));
    ccap_channel #(.TW(TW)) u_ch (
      .clk(clk), .rst_ni(rst_i), .tbase(tbase), .ovf_evt(ovf),
      .pin_rise(rise_v[g]), .pin_fall(fall_v[g]),
      .cmp_chg(rise_v[NCH] | fall_v[NCH]),
      .ctrl_we(ctrl_wr && sel), .data_we(lo_wr && sel),
      .wbyte(reg_wdata), .wdata_full(wfull),
      .ctrl_rd(ctrl_rd[g]), .data_rd(data_rd[g]),
      .hit(hit_v[g]), .clr_req(clr_v[g]), .flag(flag_v[g]), .out(chan_out[g])
    );
  end

  assign irq = |flag_v;

  always_comb begin
    unique case (win_e'(reg_addr))
      WIN_IDX:  reg_rdata = 8'(idx_q);
      WIN_CTRL: reg_rdata = ctrl_rd[idx_q];
      WIN_LO:   reg_rdata = data_rd[idx_q][7:0];
      default:  reg_rdata = 8'(data_rd[idx_q][TW-1:8]);
    endcase
  end
endmodule

// File: rtl/ccap_array_chk.sv
module ccap_array_chk #(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input logic           clk,
  input logic           rst_i,
  input logic [TW-1:0]  tbase,
  input logic           clr_any,
  input logic [NCH-1:0] flag_v,
  input logic           ctrl_wr,
  input logic [NCH-1:0] hit_v,
  input logic [NCH-1:0] chan_out
);
  // R2
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !clr_any |=> tbase == $past(tbase) + 1'b1);

  // R9
  tb_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    clr_any |=> tbase == '0);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !ctrl_wr |=> (flag_v & $past(flag_v)) == $past(flag_v));

  // R8
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    hit_v == '0 |=> $stable(chan_out));

  // R10
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    hit_v != '0 |=> (flag_v & $past(hit_v)) == $past(hit_v));
endmodule

bind ccap_array ccap_array_chk #(.NCH(NCH), .TW(TW)) u_chk (
  .clk(clk), .rst_i(rst_i), .tbase(tbase), .clr_any(clr_any),
  .flag_v(flag_v), .ctrl_wr(ctrl_wr), .hit_v(hit_v), .chan_out(chan_out)
);

// File: tb/sim_ccap_array.sv
module sim_ccap_array;
  localparam int NCH = 4;
  localparam int TW  = 12;
  localparam logic [TW-1:0] TMAX = '1;

  logic           clk, rst_n, reg_wr, cmp_in;
  logic [1:0]     reg_addr;
  logic [7:0]     reg_wdata, reg_rdata;
  logic [NCH-1:0] pin_in, chan_out;
  logic           irq;
  logic [TW-1:0]  tbase;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  ccap_array #(.NCH(NCH), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .cmp_in(cmp_in), .chan_out(chan_out), .irq(irq), .tbase(tbase)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req[3:0], wr, addr[1:0], wdata[7:0], expect[7:0]}
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {4'd3, 1'b1, 2'd0, 8'h02, 8'h00},  // R3 select channel 2
    {4'd3, 1'b0, 2'd0, 8'h00, 8'h02},
    {4'd4, 1'b1, 2'd3, 8'h0A, 8'h00},  // R4 hold high byte
    {4'd4, 1'b0, 2'd3, 8'h00, 8'h00},  // R4 not applied yet
    {4'd4, 1'b1, 2'd2, 8'h5C, 8'h00},
    {4'd4, 1'b0, 2'd2, 8'h00, 8'h5C},
    {4'd4, 1'b0, 2'd3, 8'h00, 8'h0A},
    {4'd3, 1'b1, 2'd0, 8'h05, 8'h00},  // R3 only low bits kept
    {4'd3, 1'b0, 2'd0, 8'h00, 8'h01},
    {4'd3, 1'b0, 2'd2, 8'h00, 8'h00},  // R3 channel 1 untouched
    {4'd3, 1'b1, 2'd1, 8'h06, 8'h00},
    {4'd3, 1'b0, 2'd1, 8'h00, 8'h06},
    {4'd10, 1'b1, 2'd1, 8'hE8, 8'h00}, // R10 reserved bits, flag stays 0
    {4'd10, 1'b0, 2'd1, 8'h00, 8'h08},
    {4'd3, 1'b1, 2'd0, 8'h02, 8'h00},
    {4'd4, 1'b1, 2'd3, 8'hFF, 8'h00},
    {4'd4, 1'b1, 2'd2, 8'h00, 8'h00},
    {4'd4, 1'b0, 2'd3, 8'h00, 8'h0F},  // R4 masked high bits
    {4'd3, 1'b0, 2'd1, 8'h00, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_data(output logic [TW-1:0] v);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    v = {hi[TW-9:0], lo};
  endtask

  // drive one edge on an input, return time base value expected in the capture
  task automatic pulse_pin(input int ch, input logic val, output logic [TW-1:0] t);
    if (ch < NCH) pin_in[ch] = val;
    else          cmp_in = val;
    tick();
    tick();
    t = tbase;
    tick();
  endtask

  initial begin
    logic [7:0]    v;
    logic [TW-1:0] t, d, got;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    pin_in = '0; cmp_in = 1'b0;
    #22;
    // R1 reset state
    chk("R1 tbase", 32'(tbase), 32'h0);
    chk("R1 irq/out", 32'({irq, chan_out}), 32'h0);
    rd(2'd1, v); chk("R1 ctrl", 32'(v), 32'h0);
    rd(2'd0, v); chk("R1 index", 32'(v), 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R2 increment
    t = tbase; tick();
    chk("R2 step", 32'(tbase), 32'(t + 1'b1));

    // R3 R4 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][17:16], v);
        nchk++;
        if (v !== VEC[i][7:0]) begin
          nerr++;
          $display("FAIL R%0d entry %0d actual=%0h expected=%0h",
                   VEC[i][22:19], i, v, VEC[i][7:0]);
        end
      end
    end

    // R5 rising capture on channel 0 (default control)
    wr(2'd0, 8'd0);
    pulse_pin(0, 1'b1, t);
    rd_data(got); chk("R5 rise data", 32'(got), 32'(t));
    rd(2'd1, v);  chk("R5 flag", 32'(v), 32'h80);
    chk("R10 irq", 32'(irq), 32'h1);

    // R5 falling capture on channel 1 (control 08)
    wr(2'd0, 8'd1);
    pin_in[1] = 1'b1; repeat (4) tick();
    rd(2'd1, v); chk("R5 no capture on rise", 32'(v), 32'h08);
    pulse_pin(1, 1'b0, t);
    rd_data(got); chk("R5 fall data", 32'(got), 32'(t));

    // R6 overflow capture on channel 2, R2 wrap
    wr(2'd0, 8'd2);
    wr(2'd1, 8'h10);
    for (int k = 0; k < 5000 && tbase != TMAX; k++) tick();
    tick();
    chk("R2 wrap", 32'(tbase), 32'h0);
    rd_data(got); chk("R6 ovf data", 32'(got), 32'(TMAX));
    rd(2'd1, v);  chk("R6 flag", 32'(v), 32'h90);
    wr(2'd1, 8'h00);

    // R7 comparator both edges on channel 3
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h18);
    pulse_pin(NCH, 1'b1, t);
    rd_data(got); chk("R7 cmp rise", 32'(got), 32'(t));
    repeat (3) tick();
    pulse_pin(NCH, 1'b0, t);
    rd_data(got); chk("R7 cmp fall", 32'(got), 32'(t));

    // R10 writing 1 keeps flag, writing 0 clears
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk("R10 keep", 32'(v), 32'h80);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd1); wr(2'd1, 8'h08);
    wr(2'd0, 8'd3); wr(2'd1, 8'h18);
    rd(2'd1, v); chk("R10 clear", 32'(v), 32'h18);
    chk("R10 irq low", 32'(irq), 32'h0);

    // R8 compare with toggle on channel 0
    wr(2'd0, 8'd0);
    d = tbase + TW'(40);
    wr(2'd3, 8'(d[TW-1:8]));
    wr(2'd2, d[7:0]);
    wr(2'd1, 8'h05);
    chk("R8 out before", 32'(chan_out[0]), 32'h0);
    for (int k = 0; k < 5000 && tbase != d; k++) tick();
    tick();
    chk("R8 toggle", 32'(chan_out[0]), 32'h1);
    chk("R8 irq", 32'(irq), 32'h1);
    rd(2'd1, v); chk("R8 flag", 32'(v), 32'h85);
    wr(2'd1, 8'h01);

    // R9 two channels clear at match 20
    wr(2'd0, 8'd2);
    wr(2'd3, 8'h00); wr(2'd2, 8'd20); wr(2'd1, 8'h03);
    wr(2'd0, 8'd3);
    wr(2'd3, 8'h00); wr(2'd2, 8'd20); wr(2'd1, 8'h03);
    for (int k = 0; k < 5000 && tbase != TW'(20); k++) tick();
    tick();
    chk("R9 cleared", 32'(tbase), 32'h0);
    repeat (20) tick();
    chk("R9 period top", 32'(tbase), 32'd20);
    tick();
    chk("R9 period", 32'(tbase), 32'h0);
    chk("R8 no toggle", 32'(chan_out[0]), 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule